// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command decoder and operation sequencer for a 16-bit NOR-style flash array. Software talks to it only through bus write cycles. A write cycle is accepted when write enable rises while chip enable is low. The low byte of the data bus carries the command code. The controller picks what a bus read returns: the array contents, the identifier words, or the status byte.

Block erase and word write each take two bus cycles. The second cycle starts an internal operation whose length is a parameter count of clock cycles, and the ready flag is low while it runs. A running operation can be suspended and later resumed. Errors are latched in the status byte until software clears them. The two lowest blocks are boot blocks, and a hardware lock can protect them.

The storage is a behavioural array sized by parameters. The address map keeps the full-size ratios: eight small blocks share the lowest big-block slot, and big blocks cover the rest of the space. The default uses 16-word small blocks, 128-word big blocks and 1024 words. Full size would be AW=20, SMALL_AW=12, BIG_AW=15.

Top module: `flash_cui_ctrl`

## Requirements
- R1: Power-down (rp_n low) and synchronous reset have the same effect. Either one aborts any operation, selects array read, sets the status byte to 80h, and holds rdy and rdy_drive high. While rp_n is low, dout_en stays 0.
- R2: After command FFh, reads return the array word at addr. After reset every word reads FFFFh.
- R3: After command 90h, a read at address 0 returns MFR_ID, a read at address 1 returns DEV_ID, and a read at any other address returns 0000h.
- R4: After command 70h, reads return the status byte in bits 7:0, with bits 15:8 zero. The bit weights are:
  - 80h: ready
  - 40h: erase suspended
  - 20h: erase error
  - 10h: write error
  - 08h: voltage low
  - 04h: write suspended
  - 02h: protect abort
  - 01h: always 0
- R5: 40h or 10h followed by a data cycle starts a word write. The write holds rdy low for exactly WRITE_CYC cycles and then stores old AND data at the target address.
- R6: 20h followed by D0h starts an erase. When it ends, every word of the block that contains the confirm address reads FFFFh, and words outside that block are unchanged. Blocks below address 2^BIG_AW are 2^SMALL_AW words; all others are 2^BIG_AW words.
- R7: If the cycle after 20h is not D0h, status bits 5 and 4 are set, no operation starts, and the array is unchanged.
- R8: Command 50h clears status bits 5, 4, 3 and 1.
- R9: If vpp_ok is low at a confirm or data cycle, the operation does not run. Status bit 3 is set, together with bit 5 for an erase or bit 4 for a write.
- R10: The two lowest small blocks are locked when wp_n is low and rp_hv is low. An erase or write aimed at a locked block aborts, sets status bit 1 and sets the bit for that operation. Driving wp_n high or rp_hv high unlocks them.
- R11: B0h during a running operation pauses it. rdy goes high, rdy_drive goes low, and status bit 6 (erase) or bit 2 (write) is set. Reads in array mode are then allowed. D0h resumes the operation, and it completes with the correct result.
- R12: A B0h write that lands on the cycle in which the operation completes is ignored. The operation finishes, no suspend bit is set, and rdy_drive stays high.
- R13: dout_en is high only while ce_n and oe_n are low and we_n and rp_n are high. A rising we_n while ce_n is high is not a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge captures a cycle |
| rp_n | input | 1 | Reset / power-down, active low |
| rp_hv | input | 1 | Reset pin at high-voltage level (unlocks boot blocks) |
| wp_n | input | 1 | Write protect, active low |
| vpp_ok | input | 1 | Programming voltage is in range |
| addr | input | AW | Word address |
| din | input | DW | Write data / command code (bits 7:0) |
| dout | output | DW | Read data, zero when not enabled |
| dout_en | output | DW/16 | Output driver enable (1 bit) |
| rdy | output | 1 | Ready (low while an operation runs) |
| rdy_drive | output | 1 | Ready pin driven; low models release while suspended |

## Verification
Two functions can fall in the same clock edge: a suspend command and the last count of a running operation. The bench sets WRITE_CYC to a known value and lines up the write-enable rise of a B0h cycle with the final cycle of a word write. It then repeats this one cycle earlier.

In the coincident case it expects no suspend bit, rdy_drive high, and the written value in the array. In the early case it expects the write-suspended status, and then completion after a resume. Random word writes and erases are run against a bench model of the array and its block map, so that boundary words and neighbouring blocks are compared.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } rd_mode_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_ERASE,
        PD_WRITE
    } pend_e;

    typedef enum logic {
        OP_ERASE,
        OP_WRITE
    } op_e;

    typedef struct packed {
        logic ready;
        logic ers_susp;
        logic ers_err;
        logic wr_err;
        logic vpp_low;
        logic wr_susp;
        logic prot_err;
        logic rsvd;
    } status_t;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_ID     = 8'h90;
    localparam logic [7:0] CMD_READ_SR     = 8'h70;
    localparam logic [7:0] CMD_CLEAR_SR    = 8'h50;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_WRITE_SETUP = 8'h40;
    localparam logic [7:0] CMD_WRITE_ALT   = 8'h10;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

    localparam status_t SR_IDLE = '{ready: 1'b1, default: 1'b0};

    function automatic status_t sr_clear_errors(status_t s);
        status_t r;
        r          = s;
        r.ers_err  = 1'b0;
        r.wr_err   = 1'b0;
        r.vpp_low  = 1'b0;
        r.prot_err = 1'b0;
        return r;
    endfunction

    function automatic status_t sr_flag_op_error(status_t s, logic is_erase);
        status_t r;
        r = s;
        if (is_erase) r.ers_err = 1'b1;
        else          r.wr_err  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/fcc_blkmap.sv
module fcc_blkmap #(
    parameter int AW        = 10,
    parameter int SMALL_AW  = 4,
    parameter int BIG_AW    = 7,
    parameter int BOOT_BLKS = 2
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] blk_base,
    output logic [AW-1:0] blk_mask,
    output logic          in_boot
);
    localparam logic [AW-1:0] SMALL_MASK = AW'((1 << SMALL_AW) - 1);
    localparam logic [AW-1:0] BIG_MASK   = AW'((1 << BIG_AW) - 1);
    localparam logic [AW-1:0] BOOT_TOP   = AW'(BOOT_BLKS << SMALL_AW);

    logic small_region;

    always_comb begin
        small_region = (addr >> BIG_AW) == '0;
        blk_mask     = small_region ? SMALL_MASK : BIG_MASK;
        blk_base     = addr & ~blk_mask;
        in_boot      = addr < BOOT_TOP;
    end
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          start,
    input  logic [CW-1:0] dur,
    input  logic          hold,
    output logic          busy,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= dur;
        end else if (busy && !hold) begin
            if (cnt == CW'(1)) busy <= 1'b0;
            cnt <= cnt - CW'(1);
        end
    end

    assign last = busy && (cnt == CW'(1));

    p_start_when_idle_r5: assert property (@(posedge clk) disable iff (rst || clr)
        start |-> !busy);
    p_hold_keeps_count_r11: assert property (@(posedge clk) disable iff (rst || clr)
        (busy && hold && !start) |=> (busy && $stable(cnt)));
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          er_en,
    input  logic [AW-1:0] er_base,
    input  logic [AW-1:0] er_mask
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (er_en) begin
            for (int i = 0; i < DEPTH; i++)
                if ((AW'(i) & ~er_mask) == er_base) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cui_ctrl.sv
module flash_cui_ctrl
    import fcc_pkg::*;
#(
    parameter int          AW        = 10,
    parameter int          DW        = 16,
    parameter int          SMALL_AW  = 4,
    parameter int          BIG_AW    = 7,
    parameter int          ERASE_CYC = 40,
    parameter int          WRITE_CYC = 6,
    parameter logic [15:0] MFR_ID    = 16'h00C5,
    parameter logic [15:0] DEV_ID    = 16'h4A12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          rp_n,
    input  logic          rp_hv,
    input  logic          wp_n,
    input  logic          vpp_ok,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          rdy,
    output logic          rdy_drive
);
    localparam int MAX_CYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    rd_mode_e      mode;
    pend_e         pend;
    op_e           op_kind;
    status_t       sr_q, sr_view;
    logic          susp, we_q;
    logic [AW-1:0] op_addr, op_base, op_mask;
    logic [DW-1:0] op_data;

    logic          wr_evt, running, locked, start, susp_take, op_done;
    logic [7:0]    cmd;
    logic [AW-1:0] bm_base, bm_mask;
    logic          bm_boot;
    logic          t_busy, t_last;
    logic [DW-1:0] arr_rd, rd_val;
    logic [CW-1:0] start_dur;

    assign cmd       = din[7:0];
    assign wr_evt    = !we_q && we_n && !ce_n && rp_n;
    assign running   = t_busy && !susp;
    assign locked    = bm_boot && !wp_n && !rp_hv;
    assign start     = wr_evt && !running && vpp_ok && !locked &&
                       ((pend == PD_ERASE && cmd == CMD_CONFIRM) || pend == PD_WRITE);
    assign susp_take = wr_evt && running && cmd == CMD_SUSPEND && !t_last;
    assign op_done   = t_busy && t_last && !susp;
    assign start_dur = (pend == PD_ERASE) ? CW'(ERASE_CYC) : CW'(WRITE_CYC);

    fcc_blkmap #(.AW(AW), .SMALL_AW(SMALL_AW), .BIG_AW(BIG_AW), .BOOT_BLKS(2)) u_map (
        .addr(addr), .blk_base(bm_base), .blk_mask(bm_mask), .in_boot(bm_boot)
    );

    fcc_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clr(!rp_n), .start(start), .dur(start_dur),
        .hold(susp || susp_take), .busy(t_busy), .last(t_last)
    );

    fcc_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst(rst), .rd_addr(addr), .rd_data(arr_rd),
        .wr_en(op_done && op_kind == OP_WRITE), .wr_addr(op_addr), .wr_data(op_data),
        .er_en(op_done && op_kind == OP_ERASE), .er_base(op_base), .er_mask(op_mask)
    );

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            mode    <= RM_ARRAY;
            pend    <= PD_NONE;
            sr_q    <= SR_IDLE;
            susp    <= 1'b0;
            we_q    <= 1'b1;
            op_kind <= OP_WRITE;
            op_addr <= '0;
            op_data <= '0;
            op_base <= '0;
            op_mask <= '0;
        end else begin
            we_q <= we_n;
            if (wr_evt) begin
                if (running) begin
                    if (susp_take) begin
                        susp <= 1'b1;
                        mode <= RM_STATUS;
                        if (op_kind == OP_ERASE) sr_q.ers_susp <= 1'b1;
                        else                     sr_q.wr_susp  <= 1'b1;
                    end else if (cmd == CMD_READ_SR) begin
                        mode <= RM_STATUS;
                    end
                end else if (pend != PD_NONE) begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (pend == PD_ERASE && cmd != CMD_CONFIRM) begin
                        sr_q.ers_err <= 1'b1;
                        sr_q.wr_err  <= 1'b1;
                    end else if (!vpp_ok) begin
                        sr_q         <= sr_flag_op_error(sr_q, pend == PD_ERASE);
                        sr_q.vpp_low <= 1'b1;
                    end else if (locked) begin
                        sr_q          <= sr_flag_op_error(sr_q, pend == PD_ERASE);
                        sr_q.prot_err <= 1'b1;
                    end else begin
                        op_kind <= (pend == PD_ERASE) ? OP_ERASE : OP_WRITE;
                        op_addr <= addr;
                        op_data <= din;
                        op_base <= bm_base;
                        op_mask <= bm_mask;
                    end
                end else begin
                    case (cmd)
                        CMD_READ_ARRAY: mode <= RM_ARRAY;
                        CMD_READ_ID:    mode <= RM_IDENT;
                        CMD_READ_SR:    mode <= RM_STATUS;
                        CMD_CLEAR_SR:   sr_q <= sr_clear_errors(sr_q);
                        CMD_ERASE_SETUP: if (!t_busy) begin
                            pend <= PD_ERASE;
                            mode <= RM_STATUS;
                        end
                        CMD_WRITE_SETUP, CMD_WRITE_ALT: if (!t_busy) begin
                            pend <= PD_WRITE;
                            mode <= RM_STATUS;
                        end
                        CMD_CONFIRM: if (susp) begin
                            susp          <= 1'b0;
                            sr_q.ers_susp <= 1'b0;
                            sr_q.wr_susp  <= 1'b0;
                            mode          <= RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        sr_view       = sr_q;
        sr_view.ready = !running;
        sr_view.rsvd  = 1'b0;
        case (mode)
            RM_ARRAY:  rd_val = arr_rd;
            RM_IDENT:  rd_val = (addr == AW'(0)) ? DW'(MFR_ID) :
                                (addr == AW'(1)) ? DW'(DEV_ID) : '0;
            RM_STATUS: rd_val = {{(DW-8){1'b0}}, sr_view};
            default:   rd_val = '0;
        endcase
    end

    assign dout_en   = !ce_n && !oe_n && we_n && rp_n;
    assign dout      = dout_en ? rd_val : '0;
    assign rdy       = !running;
    assign rdy_drive = !susp;

    p_rdy_falls_on_cmd_r5: assert property (@(posedge clk) disable iff (rst || !rp_n)
        $fell(rdy) |-> $past(wr_evt));
    p_susp_needs_cmd_r11: assert property (@(posedge clk) disable iff (rst || !rp_n)
        $rose(susp) |-> $past(wr_evt && din[7:0] == CMD_SUSPEND));
    p_last_cycle_suspend_r12: assert property (@(posedge clk) disable iff (rst || !rp_n)
        (wr_evt && t_busy && !susp && t_last && din[7:0] == CMD_SUSPEND) |=> (!susp && rdy));
    p_improper_seq_r7: assert property (@(posedge clk) disable iff (rst || !rp_n)
        (wr_evt && !t_busy && pend == PD_ERASE && din[7:0] != CMD_CONFIRM)
        |=> (sr_q.ers_err && sr_q.wr_err && rdy));
    p_boot_lock_r10: assert property (@(posedge clk) disable iff (rst || !rp_n)
        (wr_evt && !t_busy && bm_boot && !wp_n && !rp_hv && vpp_ok &&
         (pend == PD_WRITE || (pend == PD_ERASE && din[7:0] == CMD_CONFIRM)))
        |=> (rdy && sr_q.prot_err));
    p_powerdown_mode_r1: assert property (@(posedge clk) disable iff (rst)
        !rp_n |=> (mode == RM_ARRAY && !t_busy));
endmodule

// File: tb/test_flash_cui_ctrl.sv
module test_flash_cui_ctrl;
    localparam int AW = 10, DW = 16, SMALL_AW = 4, BIG_AW = 7;
    localparam int ERASE_CYC = 40, WRITE_CYC = 6;
    localparam logic [15:0] MFR = 16'h00C5, DEV = 16'h4A12;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, ce_n, oe_n, we_n, rp_n, rp_hv, wp_n, vpp_ok;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic dout_en, rdy, rdy_drive;

    flash_cui_ctrl #(.AW(AW), .DW(DW), .SMALL_AW(SMALL_AW), .BIG_AW(BIG_AW),
                     .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC),
                     .MFR_ID(MFR), .DEV_ID(DEV)) i_flash_cui_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .rp_hv(rp_hv), .wp_n(wp_n), .vpp_ok(vpp_ok), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .rdy(rdy), .rdy_drive(rdy_drive)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] model [DEPTH];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int blk_lo(input int a);
        if (a < (1 << BIG_AW)) return a & ~((1 << SMALL_AW) - 1);
        return a & ~((1 << BIG_AW) - 1);
    endfunction

    function automatic int blk_hi(input int a);
        if (a < (1 << BIG_AW)) return blk_lo(a) + (1 << SMALL_AW) - 1;
        return blk_lo(a) + (1 << BIG_AW) - 1;
    endfunction

    task automatic bus_wr(input int a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = AW'(a); din = d;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = AW'(a);
        #1 v = dout;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_rdy();
        for (int n = 0; n < 2000 && !rdy; n++) @(negedge clk);
    endtask

    task automatic rd_status(output logic [15:0] v);
        bus_wr(0, 16'h0070);
        rd(0, v);
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic [7:0] c);
        bus_wr(a, {8'h00, c});
        bus_wr(a, d);
        wait_rdy();
        model[a] = model[a] & d;
        bus_wr(0, 16'h00FF);
    endtask

    task automatic do_erase(input int a);
        bus_wr(a, 16'h0020);
        bus_wr(a, 16'h00D0);
        wait_rdy();
        for (int i = blk_lo(a); i <= blk_hi(a); i++) model[i] = 16'hFFFF;
        bus_wr(0, 16'h00FF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, d;
        int a, n;
        void'($urandom(32'd20240611));
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; rp_n = 1'b1;
        rp_hv = 1'b0; wp_n = 1'b1; vpp_ok = 1'b1; addr = '0; din = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 / R13: reset state
        check("R1 rdy after reset", {15'd0, rdy}, 16'd1);
        check("R1 rdy_drive after reset", {15'd0, rdy_drive}, 16'd1);
        check("R13 dout_en idle", {15'd0, dout_en}, 16'd0);
        rd(5, v);  check("R2 erased read after reset", v, 16'hFFFF);

        // R4: status after reset
        rd_status(v); check("R4 status idle", v, 16'h0080);

        // R3: identifier
        bus_wr(0, 16'h0090);
        rd(0, v); check("R3 manufacturer id", v, MFR);
        rd(1, v); check("R3 device id", v, DEV);
        rd(2, v); check("R3 other id address", v, 16'h0000);
        bus_wr(0, 16'h00FF);

        // R5: word write timing and AND result
        bus_wr(200, 16'h0040);
        bus_wr(200, 16'hA5C3);
        n = 0;
        while (!rdy && n < 1000) begin n++; @(negedge clk); end
        check("R5 busy length", 16'(n), 16'(WRITE_CYC));
        model[200] = 16'hA5C3;
        bus_wr(0, 16'h00FF);
        rd(200, v); check("R5 first write", v, 16'hA5C3);
        do_write(200, 16'h0F0F, 8'h10);
        rd(200, v); check("R5 second write ANDs", v, 16'h0503);

        // R6: erase of a big block, neighbours kept
        do_write(127, 16'h1111, 8'h40);
        do_write(256, 16'h2222, 8'h40);
        do_write(255, 16'h3333, 8'h40);
        do_erase(150);
        rd(128, v); check("R6 big block low edge", v, 16'hFFFF);
        rd(255, v); check("R6 big block high edge", v, 16'hFFFF);
        rd(200, v); check("R6 big block middle", v, 16'hFFFF);
        rd(127, v); check("R6 lower neighbour kept", v, 16'h1111);
        rd(256, v); check("R6 upper neighbour kept", v, 16'h2222);
        // R6: erase of a small block
        do_write(16, 16'h4444, 8'h40);
        do_write(31, 16'h5555, 8'h40);
        do_write(32, 16'h6666, 8'h40);
        do_write(15, 16'h7777, 8'h40);
        do_erase(20);
        rd(16, v); check("R6 small block low edge", v, 16'hFFFF);
        rd(31, v); check("R6 small block high edge", v, 16'hFFFF);
        rd(32, v); check("R6 small neighbour above", v, 16'h6666);
        rd(15, v); check("R6 small neighbour below", v, 16'h7777);

        // R7 / R8: improper erase sequence, then clear
        bus_wr(300, 16'h0020);
        bus_wr(300, 16'h00FF);
        check("R7 no busy", {15'd0, rdy}, 16'd1);
        rd(300, v); check("R7 status after improper", v, 16'h00B0);
        bus_wr(0, 16'h0050);
        rd_status(v); check("R8 clear status", v, 16'h0080);
        bus_wr(0, 16'h00FF);
        rd(32, v); check("R7 array unchanged", v, 16'h6666);

        // R9: programming voltage low
        vpp_ok = 1'b0;
        bus_wr(32, 16'h0040); bus_wr(32, 16'h0000);
        rd(0, v); check("R9 write vpp low status", v, 16'h0098);
        bus_wr(0, 16'h0050);
        bus_wr(32, 16'h0020); bus_wr(32, 16'h00D0);
        rd(0, v); check("R9 erase vpp low status", v, 16'h00A8);
        bus_wr(0, 16'h0050); bus_wr(0, 16'h00FF);
        vpp_ok = 1'b1;
        rd(32, v); check("R9 array unchanged", v, 16'h6666);

        // R10: boot block lock
        do_write(3, 16'h3C3C, 8'h40);
        wp_n = 1'b0; rp_hv = 1'b0;
        bus_wr(3, 16'h0020); bus_wr(3, 16'h00D0);
        check("R10 lock no busy", {15'd0, rdy}, 16'd1);
        rd(0, v); check("R10 erase lock status", v, 16'h00A2);
        bus_wr(0, 16'h0050);
        bus_wr(20, 16'h0040); bus_wr(20, 16'h0000);
        rd(0, v); check("R10 write lock status", v, 16'h0092);
        bus_wr(0, 16'h0050); bus_wr(0, 16'h00FF);
        rd(3, v); check("R10 locked word kept", v, 16'h3C3C);
        do_write(40, 16'h00F0, 8'h40);
        rd(40, v); check("R10 non-boot block writable", v, 16'h00F0);
        rp_hv = 1'b1;
        do_erase(3);
        rd(3, v); check("R10 high-voltage unlock", v, 16'hFFFF);
        rp_hv = 1'b0; wp_n = 1'b1;

        // R11: erase suspend and resume
        do_write(520, 16'h1234, 8'h40);
        bus_wr(512, 16'h0020); bus_wr(512, 16'h00D0);
        repeat (5) @(negedge clk);
        bus_wr(0, 16'h00B0);
        check("R11 rdy high when suspended", {15'd0, rdy}, 16'd1);
        check("R11 rdy released when suspended", {15'd0, rdy_drive}, 16'd0);
        rd(0, v); check("R11 erase suspend status", v, 16'h00C0);
        bus_wr(0, 16'h00FF);
        rd(520, v); check("R11 array read while suspended", v, 16'h1234);
        bus_wr(0, 16'h00D0);
        check("R11 busy after resume", {15'd0, rdy}, 16'd0);
        wait_rdy();
        for (int i = 512; i < 640; i++) model[i] = 16'hFFFF;
        rd_status(v); check("R11 status after resumed erase", v, 16'h0080);
        bus_wr(0, 16'h00FF);
        rd(520, v); check("R11 erase completed", v, 16'hFFFF);
        // R11: write suspend, one cycle before completion
        bus_wr(700, 16'h0040); bus_wr(700, 16'h00FF);
        repeat (WRITE_CYC - 4) @(negedge clk);
        bus_wr(0, 16'h00B0);
        rd(0, v); check("R11 write suspend late", v, 16'h0084);
        bus_wr(0, 16'h00D0);
        wait_rdy();
        model[700] = model[700] & 16'h00FF;
        bus_wr(0, 16'h00FF);
        rd(700, v); check("R11 write after resume", v, model[700]);

        // R12: suspend on the completion cycle
        bus_wr(800, 16'h0040); bus_wr(800, 16'h0F0F);
        repeat (WRITE_CYC - 3) @(negedge clk);
        bus_wr(0, 16'h00B0);
        check("R12 rdy_drive kept", {15'd0, rdy_drive}, 16'd1);
        check("R12 rdy high", {15'd0, rdy}, 16'd1);
        rd(0, v); check("R12 no suspend bit", v, 16'h0080);
        model[800] = model[800] & 16'h0F0F;
        bus_wr(0, 16'h00FF);
        rd(800, v); check("R12 write completed", v, model[800]);

        // R13: write enable rising with chip enable high is not a command
        @(negedge clk); ce_n = 1'b1; we_n = 1'b0; din = 16'h0090; addr = '0;
        @(negedge clk); we_n = 1'b1;
        rd(0, v); check("R13 deselected write ignored", v, model[0]);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        #1 check("R13 no drive during write", {15'd0, dout_en}, 16'd0);
        ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1; oe_n = 1'b1;

        // R1: power-down returns to array read
        bus_wr(0, 16'h0070);
        @(negedge clk); rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1 check("R1 no drive in power-down", {15'd0, dout_en}, 16'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        rp_n = 1'b1;
        rd(40, v); check("R1 array mode after power-down", v, model[40]);

        // Random word writes and erases against the model
        for (int k = 0; k < 40; k++) begin
            a = int'($urandom_range(DEPTH - 1, 0));
            d = 16'($urandom);
            do_write(a, d, ($urandom % 2) ? 8'h40 : 8'h10);
            rd(a, v); check("R5 random write", v, model[a]);
        end
        for (int k = 0; k < 4; k++) begin
            a = int'($urandom_range(DEPTH - 1, 0));
            do_erase(a);
            rd(blk_lo(a), v); check("R6 random erase low", v, 16'hFFFF);
            rd(blk_hi(a), v); check("R6 random erase high", v, 16'hFFFF);
            if (blk_hi(a) + 1 < DEPTH) begin
                rd(blk_hi(a) + 1, v); check("R6 random neighbour", v, model[blk_hi(a) + 1]);
            end
        end
        for (int k = 0; k < 24; k++) begin
            a = int'($urandom_range(DEPTH - 1, 0));
            rd(a, v); check("R2 random sweep", v, model[a]);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule